// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block turns parallel left and right audio samples into a three-wire serial stream: a bit clock, a left/right word clock and one data line. It runs entirely on a single master clock at 256 times the sample rate. The bit clock is the master clock divided by four, which gives 32 bit-clock periods for each channel and 64 for each stereo frame. All three outputs come from registers clocked on the rising master edge.

One control input picks the word layout. When it is low, the top 16 bits of each 20-bit sample are sent most significant bit first and placed at the end of the channel slot (right-justified). When it is high, all 20 bits are sent least significant bit first from the start of the slot. Samples come in on a strobe and wait in a pending register until the next frame begins, so the word that is being shifted out cannot be disturbed. A zero request from the upstream error logic blanks a whole channel slot.

Top module: `audio_serial_fmt`

## Requirements
- R1: At every rising clock edge with `rst_n` low, the next state is `bclk_o`=0, `lrck_o`=1, `sdata_o`=0 and the frame position is cleared. After `rst_n` returns high, `lrck_o` stays high for exactly 128 clocks before its first fall.
- R2: `bclk_o` has a period of 4 clocks, 2 clocks high and 2 clocks low.
- R3: `sdata_o` changes only in the clock cycle where `bclk_o` falls. The receiver samples it on the rising edge of `bclk_o`.
- R4: `lrck_o` is 1 for the left channel and 0 for the right channel, changes only where `bclk_o` falls, and holds each level for 128 clocks (32 bit-clock periods). Slot 0 is the first bit-clock period after an `lrck_o` change and slot 31 is the last.
- R5: With `fmt_sel`=0, slots 16 to 31 carry sample bits 19 down to 4, in that order. Slots 0 to 15 carry 0, and sample bits 3 to 0 are not sent.
- R6: With `fmt_sel`=1, slots 0 to 19 carry sample bits 0 up to 19, in that order, and slots 20 to 31 carry 0.
- R7: A `smp_valid` pulse stores `left_in` and `right_in` as a pending pair. The pair is first sent in the frame (left half, then right half) that starts after the pulse. A pulse during a frame does not change either half of that frame.
- R8: `zero_req` is sampled once per half, on the clock before that half's first output cycle. If it is high there, every slot of that half is 0. A change in the middle of a half takes effect from the next half.
- R9: `fmt_sel` is sampled at the same point as `zero_req`. A change in the middle of a half takes effect from the next half.
- R10: When no new strobe arrives, the last stored pair is sent again in every following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock at 256 times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 1 | 0: 16-bit MSB-first right-justified, 1: 20-bit LSB-first |
| smp_valid | input | 1 | One-clock strobe that stores a new sample pair |
| left_in | input | 20 | Left channel sample |
| right_in | input | 20 | Right channel sample |
| zero_req | input | 1 | Blanks the next channel half with zeros |
| bclk_o | output | 1 | Bit clock, master clock divided by 4 |
| lrck_o | output | 1 | Word clock, high for left and low for right |
| sdata_o | output | 1 | Serial audio data |

## Verification
Two activities can fall in the same cycle: a new sample strobe, and the shifting out of the current frame. The sample that lands in pending storage must not reach the shift word until the next frame begins. The bench provokes this by strobing a different pair in the middle of the right half of a frame it is capturing. It then requires that frame to carry the old pair in both halves and the following frame to carry the new pair. In the same way, changes to the zero request and the format made in the middle of the left half must leave the left half alone and apply to the right half.

// File: rtl/afmt_pkg.sv
// Shared types for the serial audio formatter.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package afmt_pkg;

    // Word layout selected by the format input
    typedef enum logic {
        FMT_MSB_NARROW = 1'b0,  // narrow word, MSB first, right-justified
        FMT_LSB_WIDE   = 1'b1   // full word, LSB first, left-justified
    } fmt_e;

endpackage

// File: rtl/afmt_timebase.sv
// Frame position counter for the serial audio formatter.
// Splits one free-running count into bit-clock phase, slot number and
// channel half, and flags the last clock of each half and of each frame.
// Assumes: BCLK_DIV and SLOTS are powers of two, BCLK_DIV >= 2.
module afmt_timebase #(
    parameter int SLOTS    = 32,
    parameter int BCLK_DIV = 4,
    localparam int PH_W    = $clog2(BCLK_DIV),
    localparam int SL_W    = $clog2(SLOTS),
    localparam int CNT_W   = PH_W + SL_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic [SL_W-1:0] slot,
    output logic            right_half,
    output logic            end_of_half,
    output logic            end_of_frame
);

    logic [CNT_W-1:0] pos_q;

    // Free-running frame position, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // Field split and boundary flags
    always_comb begin
        phase        = pos_q[PH_W-1:0];
        slot         = pos_q[PH_W +: SL_W];
        right_half   = pos_q[CNT_W-1];
        end_of_half  = &pos_q[CNT_W-2:0];
        end_of_frame = &pos_q;
    end

endmodule

// File: rtl/afmt_word_stage.sv
// Sample storage for the serial audio formatter.
// Keeps a pending pair written by the strobe. At each frame start the left
// word goes to the shift word and the right word to a hold register. At the
// mid-frame boundary the held right word goes to the shift word. Zero and
// format requests are sampled at every half boundary.
// Assumes: end_of_frame is only ever high together with end_of_half.
module afmt_word_stage
    import afmt_pkg::*;
#(
    parameter int SAMPLE_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    input  logic                zero_req,
    input  fmt_e                fmt_in,
    input  logic                end_of_half,
    input  logic                end_of_frame,
    output logic [SAMPLE_W-1:0] word,
    output fmt_e                fmt_cur
);

    logic [SAMPLE_W-1:0] pend_l_q;
    logic [SAMPLE_W-1:0] pend_r_q;
    logic [SAMPLE_W-1:0] hold_r_q;
    logic [SAMPLE_W-1:0] word_q;
    fmt_e                fmt_q;
    logic [SAMPLE_W-1:0] next_src;

    // Capture a new pair whenever the strobe is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_l_q <= '0;
            pend_r_q <= '0;
        end else if (smp_valid) begin
            pend_l_q <= left_in;
            pend_r_q <= right_in;
        end
    end

    // Source for the next half: pending left at a frame start, held right otherwise
    always_comb begin
        next_src = end_of_frame ? pend_l_q : hold_r_q;
    end

    // Load the shift word and the half context at each half boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            hold_r_q <= '0;
            fmt_q    <= FMT_MSB_NARROW;
        end else if (end_of_half) begin
            word_q <= zero_req ? '0 : next_src;
            fmt_q  <= fmt_in;
            if (end_of_frame) begin
                hold_r_q <= pend_r_q;
            end
        end
    end

    assign word    = word_q;
    assign fmt_cur = fmt_q;

endmodule

// File: rtl/afmt_slot_mux.sv
// Slot-to-bit mapping for the serial audio formatter.
// Builds both slot layouts of the current word as vectors indexed by slot
// number, then selects one layout and one slot.
// Assumes: NARROW_W <= SAMPLE_W <= SLOTS.
module afmt_slot_mux
    import afmt_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int NARROW_W = 16,
    parameter int SLOTS    = 32,
    localparam int SL_W    = $clog2(SLOTS),
    localparam int OFFSET  = SLOTS - NARROW_W
) (
    input  logic [SAMPLE_W-1:0] word,
    input  fmt_e                fmt,
    input  logic [SL_W-1:0]     slot,
    output logic                bit_out
);

    logic [SLOTS-1:0] narrow_lane;
    logic [SLOTS-1:0] wide_lane;

    // One slot position per iteration, for each layout
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (s >= OFFSET) begin : g_nar_bit
            assign narrow_lane[s] = word[SAMPLE_W-1-(s-OFFSET)];
        end else begin : g_nar_pad
            assign narrow_lane[s] = 1'b0;
        end
        if (s < SAMPLE_W) begin : g_wid_bit
            assign wide_lane[s] = word[s];
        end else begin : g_wid_pad
            assign wide_lane[s] = 1'b0;
        end
    end

    // Pick the layout, then the slot
    always_comb begin
        bit_out = (fmt == FMT_LSB_WIDE) ? wide_lane[slot] : narrow_lane[slot];
    end

endmodule

// File: rtl/audio_serial_fmt.sv
// Serial audio output formatter, top level.
// Derives the bit clock and the word clock from the master clock and shifts
// the stored samples out in the selected layout. All outputs are registered
// on the rising master edge, so they move together one clock after the
// frame position they describe.
// Assumes: clk runs at SLOTS*2*BCLK_DIV times the sample rate.
module audio_serial_fmt
    import afmt_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int NARROW_W = 16,
    parameter int SLOTS    = 32,
    parameter int BCLK_DIV = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_sel,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    input  logic                zero_req,
    output logic                bclk_o,
    output logic                lrck_o,
    output logic                sdata_o
);

    localparam int PH_W     = $clog2(BCLK_DIV);
    localparam int SL_W     = $clog2(SLOTS);
    localparam int HALF_CYC = SLOTS * BCLK_DIV;

    logic [PH_W-1:0] phase;
    logic [SL_W-1:0] slot;
    logic            right_half;
    logic            end_of_half;
    logic            end_of_frame;
    logic [SAMPLE_W-1:0] word;
    fmt_e            fmt_cur;
    logic            bit_now;

    afmt_timebase #(
        .SLOTS    (SLOTS),
        .BCLK_DIV (BCLK_DIV)
    ) i_timebase (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase        (phase),
        .slot         (slot),
        .right_half   (right_half),
        .end_of_half  (end_of_half),
        .end_of_frame (end_of_frame)
    );

    afmt_word_stage #(
        .SAMPLE_W (SAMPLE_W)
    ) i_word_stage (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_valid    (smp_valid),
        .left_in      (left_in),
        .right_in     (right_in),
        .zero_req     (zero_req),
        .fmt_in       (fmt_e'(fmt_sel)),
        .end_of_half  (end_of_half),
        .end_of_frame (end_of_frame),
        .word         (word),
        .fmt_cur      (fmt_cur)
    );

    afmt_slot_mux #(
        .SAMPLE_W (SAMPLE_W),
        .NARROW_W (NARROW_W),
        .SLOTS    (SLOTS)
    ) i_slot_mux (
        .word    (word),
        .fmt     (fmt_cur),
        .slot    (slot),
        .bit_out (bit_now)
    );

    // Register the three wires: bit clock high in the upper half of each slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_o  <= 1'b0;
            lrck_o  <= 1'b1;
            sdata_o <= 1'b0;
        end else begin
            bclk_o  <= phase[PH_W-1];
            lrck_o  <= !right_half;
            sdata_o <= bit_now;
        end
    end

endmodule

// File: rtl/afmt_checker.sv
// Timing checks for the serial audio formatter outputs.
// Attached to every audio_serial_fmt instance by the bind below.
// Assumes: HALF_CYC is the number of clocks in one channel half.
module afmt_checker #(
    parameter int HALF_CYC = 128
) (
    input logic clk,
    input logic rst_n,
    input logic bclk,
    input logic lrck,
    input logic sdata
);

    logic        lrck_d;
    logic        seen_q;
    logic [15:0] run_q;

    // Count the clocks spent at the current word clock level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lrck_d <= 1'b1;
            seen_q <= 1'b0;
            run_q  <= '0;
        end else begin
            lrck_d <= lrck;
            if (lrck != lrck_d) begin
                run_q  <= 16'd1;
                seen_q <= 1'b1;
            end else begin
                run_q <= run_q + 16'd1;
            end
        end
    end

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!bclk && lrck && !sdata));

    p_bclk_two_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bclk) |=> $stable(bclk));

    p_data_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata) |-> $fell(bclk));

    p_lrck_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrck) |-> $fell(bclk));

    p_lrck_half_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (lrck != lrck_d)) |-> (run_q == 16'(HALF_CYC)));

endmodule

bind audio_serial_fmt afmt_checker #(
    .HALF_CYC (HALF_CYC)
) i_afmt_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .bclk  (bclk_o),
    .lrck  (lrck_o),
    .sdata (sdata_o)
);

// File: tb/test_audio_serial_fmt.sv
`timescale 1ns/1ps
module test_audio_serial_fmt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_sel = 1'b0;
    logic        smp_valid = 1'b0;
    logic [19:0] left_in = '0;
    logic [19:0] right_in = '0;
    logic        zero_req = 1'b0;
    logic        bclk_o, lrck_o, sdata_o;

    int checks = 0;
    int errors = 0;
    int viol_data = 0;
    int viol_lr = 0;

    always #2.5 clk = ~clk;

    audio_serial_fmt i_audio_serial_fmt (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .smp_valid(smp_valid),
        .left_in(left_in), .right_in(right_in), .zero_req(zero_req),
        .bclk_o(bclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o)
    );

    // {fmt, zero, left, right}
    localparam logic [41:0] TBL [8] = '{
        {1'b0, 1'b0, 20'hABCDE, 20'h12345},
        {1'b1, 1'b0, 20'hABCDE, 20'h12345},
        {1'b0, 1'b0, 20'hFFFFF, 20'h00000},
        {1'b1, 1'b0, 20'h80001, 20'h7FFFE},
        {1'b1, 1'b1, 20'hFFFFF, 20'hFFFFF},
        {1'b0, 1'b1, 20'h5A5A5, 20'hA5A5A},
        {1'b1, 1'b0, 20'h0000F, 20'hF0000},
        {1'b0, 1'b0, 20'h0000F, 20'hF0000}
    };

    // Monitor for R3 and R4: data and word clock move only where bclk falls
    logic p_b, p_l, p_d, p_rst = 1'b0;
    always @(posedge clk) begin
        #1;
        if (rst_n && p_rst) begin
            if (sdata_o != p_d && !(p_b && !bclk_o)) viol_data++;
            if (lrck_o != p_l && !(p_b && !bclk_o)) viol_lr++;
        end
        p_b = bclk_o; p_l = lrck_o; p_d = sdata_o; p_rst = rst_n;
    end

    function automatic logic exp_bit(logic f, logic z, logic [19:0] w, int s);
        if (z) return 1'b0;
        if (f) return (s < 20) ? w[s] : 1'b0;
        return (s >= 16) ? w[35 - s] : 1'b0;
    endfunction

    function automatic logic [63:0] exp_frame(logic fl, logic zl, logic [19:0] l,
                                              logic fr, logic zr, logic [19:0] r);
        logic [63:0] e;
        for (int s = 0; s < 32; s++) begin
            e[s]      = exp_bit(fl, zl, l, s);
            e[32 + s] = exp_bit(fr, zr, r, s);
        end
        return e;
    endfunction

    task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_pair(logic [19:0] l, logic [19:0] r);
        @(negedge clk);
        left_in = l; right_in = r; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Return at the negedge where lrck_o has just risen (slot 0 of left)
    task automatic wait_frame_start();
        logic p;
        p = lrck_o;
        @(negedge clk);
        while (!(lrck_o && !p)) begin
            p = lrck_o;
            @(negedge clk);
        end
    endtask

    // Sample 64 bits on bclk rising edges; count word clock level mismatches
    task automatic grab(output logic [63:0] bits, output int lr_bad);
        logic pb;
        int n;
        pb = bclk_o; n = 0; lr_bad = 0; bits = '0;
        while (n < 64) begin
            @(negedge clk);
            if (bclk_o && !pb) begin
                bits[n] = sdata_o;
                if (lrck_o != (n < 32)) lr_bad++;
                n++;
            end
            pb = bclk_o;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [63:0] bits;
        int lr_bad;
        int cnt;

        // R1: reset values
        repeat (4) @(negedge clk);
        check_int("R1 bclk in reset", int'(bclk_o), 0);
        check_int("R1 lrck in reset", int'(lrck_o), 1);
        check_int("R1 sdata in reset", int'(sdata_o), 0);
        rst_n = 1'b1;
        cnt = 0;
        @(negedge clk);
        while (lrck_o) begin cnt++; @(negedge clk); end
        check_int("R1 first left half length", cnt, 128);

        // R2: bit clock shape
        while (bclk_o) @(negedge clk);
        while (!bclk_o) @(negedge clk);
        cnt = 0;
        while (bclk_o) begin cnt++; @(negedge clk); end
        check_int("R2 bclk high clocks", cnt, 2);
        cnt = 0;
        while (!bclk_o) begin cnt++; @(negedge clk); end
        check_int("R2 bclk low clocks", cnt, 2);

        // R4: left level length
        wait_frame_start();
        cnt = 1;
        @(negedge clk);
        while (lrck_o) begin cnt++; @(negedge clk); end
        check_int("R4 lrck high clocks", cnt, 128);

        // Table of layouts, zero requests and values (R5 R6 R8 R4)
        for (int i = 0; i < 8; i++) begin
            logic f, z;
            logic [19:0] l, r;
            {f, z, l, r} = TBL[i];
            @(negedge clk);
            fmt_sel = f; zero_req = z;
            load_pair(l, r);
            wait_frame_start();
            wait_frame_start();
            grab(bits, lr_bad);
            check64(z ? "R8 table" : (f ? "R6 table" : "R5 table"),
                    bits, exp_frame(f, z, l, f, z, r));
            check_int("R4 lrck level per slot", lr_bad, 0);
        end
        @(negedge clk);
        zero_req = 1'b0;

        // R7: strobe during the right half leaves the current frame alone
        fmt_sel = 1'b1;
        load_pair(20'h13579, 20'h2468A);
        wait_frame_start();
        wait_frame_start();
        fork
            grab(bits, lr_bad);
            begin
                repeat (160) @(negedge clk);
                left_in = 20'hFEDCB; right_in = 20'h0F0F0; smp_valid = 1'b1;
                @(negedge clk);
                smp_valid = 1'b0;
            end
        join
        check64("R7 frame during strobe", bits,
                exp_frame(1, 0, 20'h13579, 1, 0, 20'h2468A));
        wait_frame_start();
        grab(bits, lr_bad);
        check64("R7 next frame carries new pair", bits,
                exp_frame(1, 0, 20'hFEDCB, 1, 0, 20'h0F0F0));
        wait_frame_start();
        grab(bits, lr_bad);
        check64("R10 pair repeats without strobe", bits,
                exp_frame(1, 0, 20'hFEDCB, 1, 0, 20'h0F0F0));

        // R8: zero request raised mid left half blanks only the right half
        load_pair(20'hC3C3C, 20'h3C3C3);
        wait_frame_start();
        wait_frame_start();
        fork
            grab(bits, lr_bad);
            begin repeat (40) @(negedge clk); zero_req = 1'b1; end
        join
        check64("R8 mid-half zero request", bits,
                exp_frame(1, 0, 20'hC3C3C, 1, 1, 20'h3C3C3));
        zero_req = 1'b0;

        // R9: format change mid left half applies from the right half
        fmt_sel = 1'b0;
        load_pair(20'h9ABCD, 20'h55AA5);
        wait_frame_start();
        wait_frame_start();
        fork
            grab(bits, lr_bad);
            begin repeat (40) @(negedge clk); fmt_sel = 1'b1; end
        join
        check64("R9 mid-half format change", bits,
                exp_frame(0, 0, 20'h9ABCD, 1, 0, 20'h55AA5));

        // R1: reset in the middle of a right half restarts the frame
        wait_frame_start();
        repeat (150) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_int("R1 lrck after mid-run reset", int'(lrck_o), 1);
        check_int("R1 sdata after mid-run reset", int'(sdata_o), 0);
        rst_n = 1'b1;
        cnt = 0;
        @(negedge clk);
        while (lrck_o) begin cnt++; @(negedge clk); end
        check_int("R1 left half length after reset", cnt, 128);

        // R3 and R4: edge alignment over the whole run
        check_int("R3 data moved off a bclk fall", viol_data, 0);
        check_int("R4 lrck moved off a bclk fall", viol_lr, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule